// File: doc/BRIEF.md
# Speculative Load Failure Resolver

This block decides what a load writes back once the load's flavour, the memory attribute of its page and its exception status are known. For each load it chooses one of three outcomes: the loaded data; a "not a thing" marker (a NaT bit for a general register, or a reserved NaT encoding for a floating-point register); or an all-zero value. It also tells the memory side to drop the access. Whatever the outcome, it carries the base-register post-increment through unchanged, so addressing side effects still happen when a load fails.

Loads arrive on a valid/ready stream and leave on a valid/ready stream through a single register stage. An input beat is taken when `in_valid` and `in_ready` are both high on a rising clock edge. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. When the consumer holds `out_ready` low while `out_valid` is high, the output stage keeps its whole result and the producer is stalled. The memory access and the register file lie outside the block.

Top module: `lsr_resolver`

## Requirements
- R1: A load whose kind code is 2'b00 (normal) is never aborted. It writes its data zero-extended with NaT clear, whatever the page attribute and the deferred-exception flag.
- R2: A load with kind code 2'b01 (speculative) or 2'b11 (speculative-advanced) that arrives with the deferred-exception flag set is aborted.
- R3: A speculative or speculative-advanced load to a page whose attribute code is not 2'b00 (cacheable) is aborted. The codes are 2'b01 limited, 2'b10 non-speculative and 2'b11 reserved, and the reserved code is handled as non-speculative.
- R4: A failed speculative-type load whose destination class bit is 0 (general register) writes value zero with the NaT output set to 1.
- R5: A failed speculative-type load whose destination class bit is 1 (floating-point register) writes the 82-bit NaT pattern with NaT output 0. The pattern is bit 81 (sign) = 0, bits 80:64 (exponent) = 17'h1FFFE, bits 63:0 (significand) = 0.
- R6: A load with kind code 2'b10 (plain advanced) to a page with attribute bit 1 set is aborted and writes zero with NaT clear, for either destination class. A plain advanced load to any other page succeeds, and its deferred-exception flag has no effect.
- R7: For every load, failed or not, the base-update enable output equals the post-increment request, and the base output equals the base input plus the sign-extended increment, modulo 2^ADDR_W.
- R8: A load that does not fail writes its data zero-extended to 82 bits, with NaT and abort both clear.
- R9: A beat accepted on an edge is presented with `out_valid` high from that edge onward. `in_ready` equals not `out_valid`, or `out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R10: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_kind | input | 2 | Load kind: 00 normal, 01 speculative, 10 advanced, 11 speculative-advanced |
| in_attr | input | 2 | Page attribute: 00 cacheable, 01 limited, 10 non-speculative, 11 reserved |
| in_defer | input | 1 | Load raised a deferred exception |
| in_is_fr | input | 1 | Destination class: 0 general, 1 floating-point |
| in_data | input | DATA_W | Loaded data |
| in_pinc | input | 1 | Post-increment requested |
| in_base | input | ADDR_W | Current base register value |
| in_inc | input | INC_W | Signed post-increment amount |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_value | output | 82 | Destination value |
| out_nat | output | 1 | General-register NaT bit |
| out_abort | output | 1 | Suppress the memory access |
| out_base_we | output | 1 | Base register writeback enable |
| out_base | output | ADDR_W | Updated base value |

## Verification
The bench sweeps every combination of kind, attribute, deferred flag and destination class. It does this first with a free-flowing consumer and then with random back-pressure. The sweep covers the reserved attribute code, which a design decoding only the listed codes would let through as a success. It also covers the plain advanced load with the deferred flag set, which a design that tests the kind loosely would turn into a NaT. A resolver that mixes up the two failure encodings shows up as a NaT bit on a floating-point destination, or a NaT pattern in a general register. A design that gates post-increment on success is caught by a cleared base-update enable on a failed load. During stalls the bench checks that the held result does not change, and that each beat comes out exactly once, in order.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  typedef enum logic [1:0] {
    LD_NORMAL   = 2'b00,
    LD_SPEC     = 2'b01,
    LD_ADV      = 2'b10,
    LD_SPEC_ADV = 2'b11
  } ld_kind_e;

  typedef enum logic [1:0] {
    PG_CACHE   = 2'b00,
    PG_LIMITED = 2'b01,
    PG_NOSPEC  = 2'b10,
    PG_RSVD    = 2'b11
  } pg_attr_e;

  typedef enum logic [1:0] {
    RES_DATA = 2'b00,
    RES_NAT  = 2'b01,
    RES_ZERO = 2'b10
  } res_e;

  localparam int FR_SIG_W = 64;
  localparam int FR_EXP_W = 17;
  localparam int FR_W     = 1 + FR_EXP_W + FR_SIG_W;
  localparam logic [FR_EXP_W-1:0] NAT_EXP = 17'h1FFFE;

  function automatic logic [FR_W-1:0] fr_nat_value();
    return {1'b0, NAT_EXP, {FR_SIG_W{1'b0}}};
  endfunction

endpackage

// File: rtl/lsr_classify.sv
module lsr_classify
  import lsr_pkg::*;
(
  input  ld_kind_e kind,
  input  pg_attr_e attr,
  input  logic     defer,
  output res_e     res,
  output logic     abort
);

  logic spec_like;
  logic page_unsafe;
  logic page_nospec;

  // kind bit 0 marks both speculative flavours
  assign spec_like   = kind[0];
  assign page_unsafe = (attr != PG_CACHE);
  // reserved code shares bit 1 with non-speculative, so it falls in here
  assign page_nospec = attr[1];

  always_comb begin
    res = RES_DATA;
    if (spec_like && (defer || page_unsafe)) begin
      res = RES_NAT;
    end else if ((kind == LD_ADV) && page_nospec) begin
      res = RES_ZERO;
    end
  end

  assign abort = (res != RES_DATA);

endmodule

// File: rtl/lsr_encode.sv
module lsr_encode
  import lsr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  res_e              res,
  input  logic              is_fr,
  input  logic [DATA_W-1:0] data,
  output logic [FR_W-1:0]   value,
  output logic              nat
);

  always_comb begin
    value = '0;
    nat   = 1'b0;
    unique case (res)
      RES_DATA: value[DATA_W-1:0] = data;
      RES_NAT: begin
        if (is_fr) value = fr_nat_value();
        else       nat   = 1'b1;
      end
      default: value = '0;
    endcase
  end

endmodule

// File: rtl/lsr_postinc.sv
module lsr_postinc #(
  parameter int ADDR_W = 64,
  parameter int INC_W  = 10
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [INC_W-1:0]  inc,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_addr
);

  localparam int EXT_W = ADDR_W - INC_W;

  logic [ADDR_W-1:0] inc_ext;

  assign inc_ext = {{EXT_W{inc[INC_W-1]}}, inc};
  assign wb_en   = en;
  assign wb_addr = base + inc_ext;

endmodule

// File: rtl/lsr_resolver.sv
module lsr_resolver
  import lsr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int INC_W  = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [1:0]             in_kind,
  input  logic [1:0]             in_attr,
  input  logic                   in_defer,
  input  logic                   in_is_fr,
  input  logic [DATA_W-1:0]      in_data,
  input  logic                   in_pinc,
  input  logic [ADDR_W-1:0]      in_base,
  input  logic [INC_W-1:0]       in_inc,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [lsr_pkg::FR_W-1:0] out_value,
  output logic                   out_nat,
  output logic                   out_abort,
  output logic                   out_base_we,
  output logic [ADDR_W-1:0]      out_base
);

  res_e              res_c;
  logic              abort_c;
  logic [FR_W-1:0]   value_c;
  logic              nat_c;
  logic              we_c;
  logic [ADDR_W-1:0] base_c;
  logic              accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  lsr_classify u_classify (
    .kind  (ld_kind_e'(in_kind)),
    .attr  (pg_attr_e'(in_attr)),
    .defer (in_defer),
    .res   (res_c),
    .abort (abort_c)
  );

  lsr_encode #(.DATA_W(DATA_W)) u_encode (
    .res   (res_c),
    .is_fr (in_is_fr),
    .data  (in_data),
    .value (value_c),
    .nat   (nat_c)
  );

  lsr_postinc #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_postinc (
    .en      (in_pinc),
    .base    (in_base),
    .inc     (in_inc),
    .wb_en   (we_c),
    .wb_addr (base_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_value   <= '0;
      out_nat     <= 1'b0;
      out_abort   <= 1'b0;
      out_base_we <= 1'b0;
      out_base    <= '0;
    end else if (accept) begin
      out_value   <= value_c;
      out_nat     <= nat_c;
      out_abort   <= abort_c;
      out_base_we <= we_c;
      out_base    <= base_c;
    end
  end

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_nat)
                                   && $stable(out_abort) && $stable(out_base))); // R9

  AST_NORMAL_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind == 2'b00) |=> !out_abort); // R1

  AST_NAT_MEANS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nat) |-> (out_abort && out_value == '0)); // R4

  AST_DEFER_SPEC_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind[0] && in_defer) |=> out_abort); // R2

  AST_PINC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_base_we == $past(in_pinc))); // R7

endmodule

// File: tb/tb_lsr_resolver.sv
module tb_lsr_resolver;

  localparam int DATA_W = 64;
  localparam int ADDR_W = 64;
  localparam int INC_W  = 10;
  localparam int FRW    = 82;

  typedef struct packed {
    logic [FRW-1:0]    value;
    logic              nat;
    logic              abort;
    logic              we;
    logic [ADDR_W-1:0] base;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_kind = '0;
  logic [1:0] in_attr = '0;
  logic in_defer = 1'b0;
  logic in_is_fr = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_pinc = 1'b0;
  logic [ADDR_W-1:0] in_base = '0;
  logic [INC_W-1:0] in_inc = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [FRW-1:0] out_value;
  logic out_nat;
  logic out_abort;
  logic out_base_we;
  logic [ADDR_W-1:0] out_base;

  int vectors = 0;
  int miscompares = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  lsr_resolver #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INC_W(INC_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_attr(in_attr), .in_defer(in_defer), .in_is_fr(in_is_fr),
    .in_data(in_data), .in_pinc(in_pinc), .in_base(in_base), .in_inc(in_inc),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_value(out_value), .out_nat(out_nat), .out_abort(out_abort),
    .out_base_we(out_base_we), .out_base(out_base)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // Expected result from the requirement text
  function automatic exp_t model(input logic [1:0] k, input logic [1:0] a, input logic d,
                                 input logic f, input logic [DATA_W-1:0] data, input logic p,
                                 input logic [ADDR_W-1:0] b, input logic [INC_W-1:0] inc,
                                 output string tag);
    exp_t e;
    e = '0;
    e.we = p;                                                   // R7
    e.base = b + {{(ADDR_W-INC_W){inc[INC_W-1]}}, inc};         // R7
    if ((k == 2'b01 || k == 2'b11) && (d || a != 2'b00)) begin
      e.abort = 1'b1;
      tag = d ? "R2" : "R3";
      if (f) begin
        e.value = {1'b0, 17'h1FFFE, 64'h0};                     // R5
        tag = {tag, ",R5"};
      end else begin
        e.nat = 1'b1;                                           // R4
        tag = {tag, ",R4"};
      end
    end else if (k == 2'b10 && (a == 2'b10 || a == 2'b11)) begin
      e.abort = 1'b1;                                           // R6
      tag = "R6";
    end else begin
      e.value = {{(FRW-DATA_W){1'b0}}, data};                   // R8
      tag = (k == 2'b00) ? "R1" : "R8";
    end
    return e;
  endfunction

  task automatic send(input logic [1:0] k, input logic [1:0] a, input logic d, input logic f,
                      input logic p, input logic [INC_W-1:0] inc);
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] b;
    string tag;
    data = {$urandom, $urandom};
    b = {$urandom, $urandom};
    @(negedge clk);
    #1;
    in_valid = 1'b1; in_kind = k; in_attr = a; in_defer = d; in_is_fr = f;
    in_data = data; in_pinc = p; in_base = b; in_inc = inc;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(k, a, d, f, data, p, b, inc, tag));
    tag_q.push_back(tag);
  endtask

  // Monitor: sets out_ready then compares the beat the next edge will take
  bit prev_stall = 1'b0;
  logic [FRW-1:0] held_value;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(out_valid === 1'b1, "R9 held valid", {127'h0, out_valid}, 128'h1);
        chk(out_value === held_value, "R9 held value", out_value, held_value);
      end
      out_ready = stall_mode ? (($urandom % 3) == 0) : 1'b1;
      if (out_valid && out_ready) begin
        exp_t e;
        string t;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected beat", 128'h1, 128'h0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_value === e.value, {t, " value"}, out_value, e.value);
          chk(out_nat === e.nat, {t, " nat"}, {127'h0, out_nat}, {127'h0, e.nat});
          chk(out_abort === e.abort, {t, " abort"}, {127'h0, out_abort}, {127'h0, e.abort});
          chk(out_base_we === e.we, "R7 base enable", {127'h0, out_base_we}, {127'h0, e.we});
          chk(out_base === e.base, "R7 base value", {64'h0, out_base}, {64'h0, e.base});
        end
      end
      prev_stall = out_valid && !out_ready;
      held_value = out_value;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected drained");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid === 1'b0, "R10 out_valid", {127'h0, out_valid}, 128'h0);
    chk(in_ready === 1'b1, "R10 in_ready", {127'h0, in_ready}, 128'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 after release", {127'h0, out_valid}, 128'h0);

    // R9 latency: one beat, visible at the negedge after its accepting edge
    send(2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 10'h004);
    chk(out_valid === 1'b0, "R9 before edge", {127'h0, out_valid}, 128'h0);
    @(negedge clk);
    chk(out_valid === 1'b1, "R9 after edge", {127'h0, out_valid}, 128'h1);
    in_valid = 1'b0;

    // Exhaustive sweep, free-flowing consumer
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 4; a++)
        for (int d = 0; d < 2; d++)
          for (int f = 0; f < 2; f++)
            send(k[1:0], a[1:0], d[0], f[0], k[0] ^ a[0], 10'($urandom));

    // Negative increment and wrap, with failing loads (R7)
    send(2'b01, 2'b10, 1'b1, 1'b0, 1'b1, 10'h3FF);
    send(2'b10, 2'b11, 1'b0, 1'b1, 1'b1, 10'h200);

    // Same sweep under random back-pressure
    stall_mode = 1'b1;
    for (int rep = 0; rep < 2; rep++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 4; a++)
          for (int d = 0; d < 2; d++)
            for (int f = 0; f < 2; f++)
              send(k[1:0], a[1:0], d[0], f[0], 1'($urandom), 10'($urandom));
    @(negedge clk);
    #1;
    in_valid = 1'b0;

    stall_mode = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b0 || out_ready === 1'b1, "R9 drained", {127'h0, out_valid}, 128'h0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule